// File: doc/BRIEF.md
# Serial Vector Dot-Product Unit

This block forms the inner product of two vectors. Each vector arrives on its own 128-bit bus as eight unsigned 16-bit elements. The unit uses one multiplier and one adder. On every clock edge it multiplies one pair of elements and adds the product to a wide running sum. It starts at element 0 and walks the element index upward.

Once the last pair has been added, the unit raises `done`. From then on it holds the sum and the index unchanged. The only way to start a new pass is an asynchronous reset. The input buses must stay stable for the eight cycles after reset is released.

The caller applies both vectors, pulses reset, and waits for `done`. While `done` is high, `dot_out` carries the complete sum.

Top module: `dotp_serial`

## Requirements
- R1: While reset is high, and on the first cycle after it is released, `dot_out` is 0 and `done` is 0. Reset takes effect without waiting for a clock edge.
- R2: Element i of each bus is taken from bits [16*i+15 : 16*i]. Element 0 sits in the least significant position.
- R3: Take the k-th rising edge after reset release, for k = 1 to 8. After that edge, `dot_out` equals the sum of the products of elements 0 to k-1.
- R4: `done` is 0 after edges 1 to 7. It is 1 after the eighth edge, and at that point `dot_out` holds the full eight-term sum.
- R5: Once `done` is 1, `done` and `dot_out` keep their values on every later edge, even when either input bus changes.
- R6: `dot_out` is 36 bits wide. With every element at 0xFFFF it shows the exact sum 8 × 0xFFFF² = 0x7FFF00008, with no wrap.
- R7: Elements are unsigned. An element whose top bit is set adds a positive product.
- R8: A reset asserted in the middle of a pass clears the sum and `done` at once. The next release starts a fresh eight-cycle pass.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Asynchronous reset, active high |
| vec_a | input | 128 | First vector, eight 16-bit elements |
| vec_b | input | 128 | Second vector, eight 16-bit elements |
| dot_out | output | 36 | Running, then final, inner product |
| done | output | 1 | High once the final sum is held |

## Verification
The bench builds the unit with its default parameters: eight elements of 16 bits and a 36-bit sum. These values bring the exact all-ones worst case within reach, along with the wrap of the 3-bit index after element 7.

Walking a single nonzero element through each lane pins down where every slice sits on the bus. Checking the partial sum after every edge exposes any skipped, repeated or late term.

// File: rtl/dotp_pkg.sv
package dotp_pkg;

  // Bits needed to index n elements (n >= 2)
  function automatic int idx_bits(input int n);
    return $clog2(n);
  endfunction

  // Smallest sum width that cannot overflow
  function automatic int sum_bits(input int elem_w, input int n);
    return 2 * elem_w + $clog2(n);
  endfunction

endpackage

// File: rtl/elem_pick.sv
module elem_pick #(
  parameter int ELEM_W = 16,
  parameter int N_ELEM = 8,
  parameter int IDX_W  = 3,
  localparam int BUS_W = ELEM_W * N_ELEM
) (
  input  logic [BUS_W-1:0]  bus,
  input  logic [IDX_W-1:0]  idx,
  output logic [ELEM_W-1:0] elem
);
  // Constant-width indexed slice, element 0 at the LSB
  assign elem = bus[idx * ELEM_W +: ELEM_W];
endmodule

// File: rtl/elem_step_ctr.sv
module elem_step_ctr #(
  parameter int N_ELEM = 8,
  parameter int IDX_W  = 3
) (
  input  logic             clk,
  input  logic             rst,
  output logic [IDX_W-1:0] idx,
  output logic             last_step,
  output logic             done
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_ELEM - 1);

  assign last_step = !done && (idx == LAST_IDX);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      idx  <= '0;
      done <= 1'b0;
    end else if (!done) begin
      idx  <= last_step ? '0 : idx + IDX_W'(1);
      done <= last_step;
    end
  end
endmodule

// File: rtl/mac_accum.sv
module mac_accum #(
  parameter int ELEM_W = 16,
  parameter int ACC_W  = 36,
  localparam int PROD_W = 2 * ELEM_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [ELEM_W-1:0] op_a,
  input  logic [ELEM_W-1:0] op_b,
  output logic [ACC_W-1:0]  acc
);
  // Unsigned product, zero-extended to the sum width
  function automatic logic [ACC_W-1:0] wide_prod(input logic [ELEM_W-1:0] x,
                                                 input logic [ELEM_W-1:0] y);
    logic [PROD_W-1:0] p;
    p = PROD_W'(x) * PROD_W'(y);
    return ACC_W'(p);
  endfunction

  always_ff @(posedge clk or posedge rst) begin
    if (rst) acc <= '0;
    else if (en) acc <= acc + wide_prod(op_a, op_b);
  end
endmodule

// File: rtl/dotp_serial.sv
module dotp_serial #(
  parameter int ELEM_W = 16,
  parameter int N_ELEM = 8,
  parameter int ACC_W  = 36,
  localparam int BUS_W = ELEM_W * N_ELEM,
  localparam int IDX_W = dotp_pkg::idx_bits(N_ELEM)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [BUS_W-1:0] vec_a,
  input  logic [BUS_W-1:0] vec_b,
  output logic [ACC_W-1:0] dot_out,
  output logic             done
);
  logic [IDX_W-1:0]  cur_idx;
  logic              final_term;
  logic              mac_fire;
  logic [ELEM_W-1:0] lane [2];
  logic [BUS_W-1:0]  bus_in [2];

  assign bus_in[0] = vec_a;
  assign bus_in[1] = vec_b;

  elem_step_ctr #(.N_ELEM(N_ELEM), .IDX_W(IDX_W)) u_ctr (
    .clk(clk), .rst(rst), .idx(cur_idx), .last_step(final_term), .done(done)
  );

  for (genvar g = 0; g < 2; g++) begin : g_pick
    elem_pick #(.ELEM_W(ELEM_W), .N_ELEM(N_ELEM), .IDX_W(IDX_W)) u_pick (
      .bus(bus_in[g]), .idx(cur_idx), .elem(lane[g])
    );
  end

  assign mac_fire = !done;

  mac_accum #(.ELEM_W(ELEM_W), .ACC_W(ACC_W)) u_mac (
    .clk(clk), .rst(rst), .en(mac_fire),
    .op_a(lane[0]), .op_b(lane[1]), .acc(dot_out)
  );
endmodule

// File: rtl/dotp_serial_chk.sv
module dotp_serial_chk #(
  parameter int N_ELEM = 8,
  parameter int ACC_W  = 36,
  localparam int CW    = $clog2(N_ELEM + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic [ACC_W-1:0] dot_out,
  input logic             done
);
  // Edges seen since reset release, saturating at N_ELEM
  logic [CW-1:0] edges;
  always_ff @(posedge clk or posedge rst) begin
    if (rst) edges <= '0;
    else if (edges != CW'(N_ELEM)) edges <= edges + CW'(1);
  end

  AST_START_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (edges == '0) |-> (dot_out == '0 && !done)); // R1
  AST_NO_EARLY_DONE: assert property (@(posedge clk) disable iff (rst)
    (edges < CW'(N_ELEM)) |-> !done); // R4
  AST_DONE_ON_TIME: assert property (@(posedge clk) disable iff (rst)
    (edges == CW'(N_ELEM)) |-> done); // R4
  AST_SUM_GROWS: assert property (@(posedge clk) disable iff (rst)
    !done |=> (dot_out >= $past(dot_out))); // R3
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
    done |=> (done && $stable(dot_out))); // R5
endmodule

bind dotp_serial dotp_serial_chk #(.N_ELEM(N_ELEM), .ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst(rst), .dot_out(dot_out), .done(done)
);

// File: tb/dotp_serial_tb.sv
module dotp_serial_tb;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [127:0] vec_a = '0;
  logic [127:0] vec_b = '0;
  logic [35:0]  dot_out;
  logic         done;
  int n_run = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  dotp_serial u_dut (.clk(clk), .rst(rst), .vec_a(vec_a), .vec_b(vec_b),
                     .dot_out(dot_out), .done(done));

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Sum of products of elements 0..k-1, slices read by shifting
  function automatic logic [63:0] ref_sum(input logic [127:0] a,
                                          input logic [127:0] b, input int k);
    logic [63:0] s = 0;
    for (int i = 0; i < k; i++)
      s += 64'((a >> (16 * i)) & 128'hFFFF) * 64'((b >> (16 * i)) & 128'hFFFF);
    return s;
  endfunction

  task automatic start_pass(input logic [127:0] a, input logic [127:0] b);
    @(negedge clk);
    vec_a = a; vec_b = b; rst = 1'b1;
    @(negedge clk);
    check(dot_out == 0 && done == 0, "R1", {dot_out, done}, 0);
    rst = 1'b0;
  endtask

  task automatic run_full(input logic [127:0] a, input logic [127:0] b,
                          input string req);
    start_pass(a, b);
    for (int k = 1; k <= 8; k++) begin
      @(posedge clk); @(negedge clk);
      check(dot_out == 36'(ref_sum(a, b, k)), {req, "/R3"}, 64'(dot_out),
            ref_sum(a, b, k));
      check(done == (k == 8), "R4", 64'(done), 64'(k == 8));
    end
    // R5: change inputs, result must hold
    vec_a = ~a; vec_b = b ^ {8{16'h1234}};
    repeat (3) begin
      @(posedge clk); @(negedge clk);
      check(done && dot_out == 36'(ref_sum(a, b, 8)), "R5", 64'(dot_out),
            ref_sum(a, b, 8));
    end
  endtask

  task automatic t_lanes;  // R2
    for (int j = 0; j < 8; j++) begin
      logic [127:0] a = 128'(j + 3) << (16 * j);
      logic [127:0] b = {8{16'd1}};
      run_full(a, b, "R2");
      check(dot_out == 36'(j + 3), "R2", 64'(dot_out), 64'(j + 3));
    end
  endtask

  task automatic t_ramp;  // R3 R4
    logic [127:0] a, b;
    for (int i = 0; i < 8; i++) begin
      a[16*i +: 16] = 16'(i * 101 + 7);
      b[16*i +: 16] = 16'(900 - i * 37);
    end
    run_full(a, b, "R4");
  endtask

  task automatic t_max;  // R6 R7
    run_full({8{16'hFFFF}}, {8{16'hFFFF}}, "R6");
    check(dot_out == 36'h7FFF00008, "R6", 64'(dot_out), 64'h7FFF00008);
    run_full({8{16'h8000}}, {8{16'h0002}}, "R7");
    check(dot_out == 36'h80000, "R7", 64'(dot_out), 64'h80000);
  endtask

  task automatic t_midreset;  // R8
    logic [127:0] a = {8{16'd5}};
    logic [127:0] b = {8{16'd9}};
    start_pass(a, b);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b1;
    #1;
    check(dot_out == 0 && done == 0, "R8", {dot_out, done}, 0);
    run_full(a, b, "R8");
    check(dot_out == 36'd360, "R8", 64'(dot_out), 64'd360);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check(dot_out == 0 && done == 0, "R1", {dot_out, done}, 0);
    t_lanes();
    t_ramp();
    t_max();
    t_midreset();
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    #400000;
    n_run++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule